// File: doc/BRIEF.md
# Push-Button Tone and Volume Controller

This block turns six active-low push-button pins into control commands for an audio processing path. Each pin passes through a synchroniser and a stable-level filter. A command fires once, on the filtered press edge, and releasing a pin fires nothing. The block has two function sets. In tone mode the pins step volume, bass and treble up or down. In alternate mode pin 0 toggles a soft-mute enable and pin 1 advances an equalisation preset index, and the other pins have no function.

A chord of two pins held for a set time switches between the two sets. Pins 4 and 5 held together move tone mode to alternate mode. Pins 2 and 3 held together move alternate mode back to tone mode. Every fired function also raises a one-cycle echo request. The request carries a mask of the pins that fired, the mode they fired in and a fixed 7-bit target address (6Ah by default), so that an external I2C master can forward the command to a second device.

The mode machine has four states. `TK_TONE_IDLE` goes to `TK_TONE_HOLD` on *enter-chord-down*. `TK_TONE_HOLD` goes back to `TK_TONE_IDLE` on *enter-chord-released*, or on to `TK_ALT_IDLE` on *enter-hold-done*. `TK_ALT_IDLE` goes to `TK_ALT_HOLD` on *exit-chord-down*. `TK_ALT_HOLD` goes back to `TK_ALT_IDLE` on *exit-chord-released*, or on to `TK_TONE_IDLE` on *exit-hold-done*.

Top module: `tone_key_ctrl`

## Requirements
- R1: After reset every pulse output, `mute_on`, `alt_mode` and `echo_req` are 0 and `preset_idx` is 0.
- R2: A pin level is accepted only after it has stayed unchanged for `DEB_US` microseconds of clock (`CLK_HZ/1e6*DEB_US` cycles) after a two-flop synchroniser. A shorter low glitch produces no command.
- R3: Each accepted press (a high-to-low filtered transition) produces exactly one single-cycle command. Release produces none.
- R4: In tone mode, pin bits 0/1 pulse `vol_up`/`vol_dn`, bits 2/3 pulse `bass_up`/`bass_dn`, and bits 4/5 pulse `treb_up`/`treb_dn`.
- R5: In alternate mode, each press of pin bit 0 inverts `mute_on`.
- R6: In alternate mode, each press of pin bit 1 advances `preset_idx` by one, from `N_PRESETS-1` back to 0. The value is always below `N_PRESETS`.
- R7: In alternate mode, presses of bits 2..5 produce no tone pulse and no echo. In tone mode, presses of bits 0 and 1 leave `mute_on` and `preset_idx` unchanged.
- R8: In tone mode, holding bits 4 and 5 low together for `HOLD_US` microseconds after filtering sets `alt_mode`. Releasing the chord earlier restarts the timing from zero.
- R9: In alternate mode, holding bits 2 and 3 low together for `HOLD_US` clears `alt_mode`. After this, tone functions respond again.
- R10: Every fired function raises `echo_req` for one cycle, in the same cycle as its pulse. `echo_mask` bit i is set when pin i fired, `echo_alt` gives the mode it fired in, and `echo_addr` equals `ECHO_ADDR` (6Ah).
- R11: Presses accepted in the same cycle all fire in that one cycle and share a single echo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_n | input | 6 | Raw button pins, low = pressed |
| vol_up | output | 1 | Volume step up pulse |
| vol_dn | output | 1 | Volume step down pulse |
| bass_up | output | 1 | Bass step up pulse |
| bass_dn | output | 1 | Bass step down pulse |
| treb_up | output | 1 | Treble step up pulse |
| treb_dn | output | 1 | Treble step down pulse |
| mute_on | output | 1 | Soft-mute enable level |
| preset_idx | output | clog2(N_PRESETS) | Selected equalisation preset |
| alt_mode | output | 1 | 1 = alternate (mute/preset) mode |
| echo_req | output | 1 | Forward-command request pulse |
| echo_mask | output | 6 | Pins that fired in this echo |
| echo_alt | output | 1 | Mode the echoed pins fired in |
| echo_addr | output | 7 | Target device address for the echo |

## Verification
Two presses can be accepted in the same cycle. The bench provokes this by pulling pins 0 and 2 low on the same clock edge, so both filters release in step. It then judges that `vol_up` and `bass_up` pulse together and that one echo carries mask 000101. The chord presses are a second case of the same kind. Pins 4 and 5 fire both treble pulses at once while the hold timer starts, and the bench checks those pulse counts as well as the later mode change.

// File: rtl/tk_pkg.sv
package tk_pkg;
    localparam int unsigned NUM_PINS = 6;

    // pin roles in tone mode
    localparam int unsigned PIN_VOL_UP  = 0;
    localparam int unsigned PIN_VOL_DN  = 1;
    localparam int unsigned PIN_BASS_UP = 2;
    localparam int unsigned PIN_BASS_DN = 3;
    localparam int unsigned PIN_TREB_UP = 4;
    localparam int unsigned PIN_TREB_DN = 5;

    // pin roles in alternate mode
    localparam int unsigned PIN_MUTE    = 0;
    localparam int unsigned PIN_PRESET  = 1;

    // chords
    localparam int unsigned ENTER_A = 4;
    localparam int unsigned ENTER_B = 5;
    localparam int unsigned EXIT_A  = 2;
    localparam int unsigned EXIT_B  = 3;

    localparam logic [NUM_PINS-1:0] ALT_LIVE_MASK = 6'b000011;

    typedef enum logic [1:0] {
        TK_TONE_IDLE = 2'd0,
        TK_TONE_HOLD = 2'd1,
        TK_ALT_IDLE  = 2'd2,
        TK_ALT_HOLD  = 2'd3
    } tk_mode_e;
endpackage

// File: rtl/tk_debounce.sv
module tk_debounce #(
    parameter int unsigned STABLE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n,
    output logic held,
    output logic press
);
    localparam int unsigned CW = $clog2(STABLE_CYC + 1);

    logic          s1_n, s2_n, lvl_n;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_n  <= 1'b1;
            s2_n  <= 1'b1;
            lvl_n <= 1'b1;
            cnt   <= '0;
            press <= 1'b0;
        end else begin
            s1_n  <= raw_n;
            s2_n  <= s1_n;
            press <= 1'b0;
            if (s2_n == lvl_n) begin
                cnt <= '0;
            end else if (cnt == CW'(STABLE_CYC - 1)) begin
                lvl_n <= s2_n;
                cnt   <= '0;
                press <= !s2_n;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign held = !lvl_n;

    // R2
    press_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        press |-> held);
endmodule

// File: rtl/tk_mode_fsm.sv
module tk_mode_fsm
    import tk_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] held,
    output logic                alt_o
);
    localparam int unsigned HW = $clog2(HOLD_CYC + 1);

    tk_mode_e      state_q, state_d;
    logic [HW-1:0] hcnt;
    logic          enter_chord, exit_chord, hold_done;

    assign enter_chord = held[ENTER_A] && held[ENTER_B];
    assign exit_chord  = held[EXIT_A]  && held[EXIT_B];
    assign hold_done   = (hcnt == HW'(HOLD_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TK_TONE_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                             hcnt <= '0;
        else if (state_q == TK_TONE_HOLD || state_q == TK_ALT_HOLD) hcnt <= hcnt + 1'b1;
        else                                                    hcnt <= '0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TK_TONE_IDLE: if (enter_chord) state_d = TK_TONE_HOLD;
            TK_TONE_HOLD: begin
                if (!enter_chord)   state_d = TK_TONE_IDLE;
                else if (hold_done) state_d = TK_ALT_IDLE;
            end
            TK_ALT_IDLE:  if (exit_chord) state_d = TK_ALT_HOLD;
            TK_ALT_HOLD: begin
                if (!exit_chord)    state_d = TK_ALT_IDLE;
                else if (hold_done) state_d = TK_TONE_IDLE;
            end
            default:      state_d = TK_TONE_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            TK_ALT_IDLE, TK_ALT_HOLD: alt_o = 1'b1;
            default:                  alt_o = 1'b0;
        endcase
    end

    // R8
    enter_chord_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alt_o) |-> $past(held[ENTER_A] && held[ENTER_B]));
    // R9
    exit_chord_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alt_o) |-> $past(held[EXIT_A] && held[EXIT_B]));
endmodule

// File: rtl/tk_cmd_decode.sv
module tk_cmd_decode
    import tk_pkg::*;
#(
    parameter int unsigned N_PRESETS = 5,
    parameter int unsigned PW        = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] press,
    input  logic                alt,
    output logic [NUM_PINS-1:0] tone_q,
    output logic                mute_q,
    output logic [PW-1:0]       preset_q,
    output logic                echo_req_q,
    output logic [NUM_PINS-1:0] echo_mask_q,
    output logic                echo_alt_q
);
    logic [NUM_PINS-1:0] fire;

    assign fire = alt ? (press & ALT_LIVE_MASK) : press;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tone_q      <= '0;
            mute_q      <= 1'b0;
            preset_q    <= '0;
            echo_req_q  <= 1'b0;
            echo_mask_q <= '0;
            echo_alt_q  <= 1'b0;
        end else begin
            tone_q      <= alt ? '0 : press;
            echo_req_q  <= |fire;
            echo_mask_q <= fire;
            echo_alt_q  <= alt;
            if (alt && press[PIN_MUTE]) mute_q <= !mute_q;
            if (alt && press[PIN_PRESET]) begin
                if (preset_q == PW'(N_PRESETS - 1)) preset_q <= '0;
                else                                preset_q <= preset_q + 1'b1;
            end
        end
    end

    // R6
    preset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(preset_q) < int'(N_PRESETS));
    // R6
    preset_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(preset_q) |-> (preset_q == '0 || preset_q == PW'($past(preset_q) + 1'b1)));
    // R5
    mute_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mute_q) |-> (echo_req_q && echo_mask_q[PIN_MUTE] && echo_alt_q));
    // R7
    alt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alt |=> (tone_q == '0));
    // R10
    echo_tone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_q != '0) |-> (echo_req_q && echo_mask_q == tone_q && !echo_alt_q));
endmodule

// File: rtl/tone_key_ctrl.sv
module tone_key_ctrl
    import tk_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned DEB_US    = 20_000,
    parameter int unsigned HOLD_US   = 1_000_000,
    parameter int unsigned N_PRESETS = 5,
    parameter logic [6:0]  ECHO_ADDR = 7'h6A,
    localparam int unsigned PW = (N_PRESETS > 1) ? $clog2(N_PRESETS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [5:0]    pins_n,
    output logic          vol_up,
    output logic          vol_dn,
    output logic          bass_up,
    output logic          bass_dn,
    output logic          treb_up,
    output logic          treb_dn,
    output logic          mute_on,
    output logic [PW-1:0] preset_idx,
    output logic          alt_mode,
    output logic          echo_req,
    output logic [5:0]    echo_mask,
    output logic          echo_alt,
    output logic [6:0]    echo_addr
);
    localparam int unsigned CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int unsigned DEB_CYC    = (CYC_PER_US * DEB_US  > 1) ? CYC_PER_US * DEB_US  : 1;
    localparam int unsigned HOLD_CYC   = (CYC_PER_US * HOLD_US > 1) ? CYC_PER_US * HOLD_US : 1;

    logic [NUM_PINS-1:0] held, press, tone;
    logic                alt;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        tk_debounce #(.STABLE_CYC(DEB_CYC)) u_deb (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_n (pins_n[i]),
            .held  (held[i]),
            .press (press[i])
        );
    end

    tk_mode_fsm #(.HOLD_CYC(HOLD_CYC)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .held  (held),
        .alt_o (alt)
    );

    tk_cmd_decode #(.N_PRESETS(N_PRESETS), .PW(PW)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .press       (press),
        .alt         (alt),
        .tone_q      (tone),
        .mute_q      (mute_on),
        .preset_q    (preset_idx),
        .echo_req_q  (echo_req),
        .echo_mask_q (echo_mask),
        .echo_alt_q  (echo_alt)
    );

    assign vol_up    = tone[PIN_VOL_UP];
    assign vol_dn    = tone[PIN_VOL_DN];
    assign bass_up   = tone[PIN_BASS_UP];
    assign bass_dn   = tone[PIN_BASS_DN];
    assign treb_up   = tone[PIN_TREB_UP];
    assign treb_dn   = tone[PIN_TREB_DN];
    assign alt_mode  = alt;
    assign echo_addr = ECHO_ADDR;
endmodule

// File: tb/tone_key_ctrl_test.sv
module tone_key_ctrl_test;
    localparam int DEB  = 8;
    localparam int HOLD = 64;
    localparam int NP   = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] pins_n = 6'h3F;
    logic vol_up, vol_dn, bass_up, bass_dn, treb_up, treb_dn;
    logic mute_on, alt_mode, echo_req, echo_alt;
    logic [2:0] preset_idx;
    logic [5:0] echo_mask;
    logic [6:0] echo_addr;

    always #10 clk = ~clk;

    tone_key_ctrl #(.CLK_HZ(1_000_000), .DEB_US(DEB), .HOLD_US(HOLD), .N_PRESETS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .pins_n(pins_n),
        .vol_up(vol_up), .vol_dn(vol_dn), .bass_up(bass_up), .bass_dn(bass_dn),
        .treb_up(treb_up), .treb_dn(treb_dn), .mute_on(mute_on), .preset_idx(preset_idx),
        .alt_mode(alt_mode), .echo_req(echo_req), .echo_mask(echo_mask),
        .echo_alt(echo_alt), .echo_addr(echo_addr)
    );

    wire [5:0] tone = {treb_dn, treb_up, bass_dn, bass_up, vol_dn, vol_up};

    int n_tests = 0;
    int n_fail  = 0;
    int got[6];
    int expc[6];
    int echo_cnt = 0;
    int echo_exp = 0;
    int bad_addr = 0;
    bit pair_seen = 0;
    bit echo_pair = 0;
    bit alt_echo_seen = 0;
    bit done = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 6; i++) if (tone[i]) got[i]++;
            if (echo_req) begin
                echo_cnt++;
                if (echo_alt) alt_echo_seen = 1;
            end
            if (echo_addr != 7'h6A) bad_addr++;
            if (vol_up && bass_up) pair_seen = 1;
            if (echo_req && echo_mask == 6'b000101) echo_pair = 1;
        end
    end

    function automatic int next_preset(int p);
        return (p + 1) % NP;
    endfunction

    function automatic bit tone_fires(int pin, bit alt);
        return !alt;
    endfunction

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_counts(string req);
        for (int i = 0; i < 6; i++) check(req, got[i], expc[i]);
        check(req, echo_cnt, echo_exp);
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(logic [5:0] m, int low_cyc);
        @(negedge clk);
        pins_n = pins_n & ~m;
        cycles(low_cyc);
        pins_n = pins_n | m;
        cycles(DEB + 6);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 100_000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            finish_run();
        end
    end

    initial begin
        int exp_preset;
        void'($urandom(32'd4242));
        for (int i = 0; i < 6; i++) begin got[i] = 0; expc[i] = 0; end
        cycles(5);
        // R1 reset state
        check("R1", int'(tone), 0);
        check("R1", int'(mute_on), 0);
        check("R1", int'(preset_idx), 0);
        check("R1", int'(alt_mode), 0);
        check("R1", int'(echo_req), 0);
        rst_n = 1'b1;
        cycles(3);

        // R2 glitch rejection
        push(6'b000001, DEB - 2);
        check_counts("R2");
        // R2 timing: nothing before the filter interval elapses
        @(negedge clk);
        pins_n[0] = 1'b0;
        cycles(DEB + 1);
        check("R2", got[0], 0);
        cycles(6);
        check("R2", got[0], 1);
        pins_n[0] = 1'b1;
        cycles(DEB + 6);
        // R3 release adds nothing
        expc[0] = 1; echo_exp = 1;
        check_counts("R3");

        // R4 directed mapping
        for (int p = 0; p < 6; p++) begin
            push(6'(1 << p), DEB + 4);
            if (tone_fires(p, 1'b0)) begin expc[p]++; echo_exp++; end
            check_counts("R4");
        end
        // R7 tone mode leaves mute/preset alone
        check("R7", int'(mute_on), 0);
        check("R7", int'(preset_idx), 0);
        // R10 echo fields
        check("R10", bad_addr, 0);
        check("R10", int'(alt_echo_seen), 0);

        // R3 random presses mixed with glitches
        for (int k = 0; k < 40; k++) begin
            int p;
            int gl;
            p  = int'($urandom % 6);
            gl = int'($urandom % 2);
            if (gl != 0) begin
                push(6'(1 << p), 1 + int'($urandom % (DEB - 2)));
            end else begin
                push(6'(1 << p), DEB + 2 + int'($urandom % 10));
                expc[p]++; echo_exp++;
            end
        end
        check_counts("R3");

        // R11 simultaneous presses
        push(6'b000101, DEB + 4);
        expc[0]++; expc[2]++; echo_exp++;
        check("R11", int'(pair_seen), 1);
        check("R10", int'(echo_pair), 1);
        check_counts("R11");

        // R8 short chord holds do not accumulate
        @(negedge clk);
        pins_n = pins_n & ~6'b110000;
        cycles(DEB + 2 + HOLD / 2);
        pins_n = pins_n | 6'b110000;
        cycles(DEB + 6);
        expc[4]++; expc[5]++; echo_exp++;
        push(6'b110000, DEB + 2 + HOLD / 2);
        expc[4]++; expc[5]++; echo_exp++;
        check("R8", int'(alt_mode), 0);
        check_counts("R8");
        // R8 full chord hold enters alternate mode
        @(negedge clk);
        pins_n = pins_n & ~6'b110000;
        cycles(DEB + HOLD + 10);
        check("R8", int'(alt_mode), 1);
        pins_n = pins_n | 6'b110000;
        cycles(DEB + 6);
        expc[4]++; expc[5]++; echo_exp++;
        check_counts("R8");

        // R5 mute toggles
        push(6'b000001, DEB + 4);
        echo_exp++;
        check("R5", int'(mute_on), 1);
        check("R10", int'(alt_echo_seen), 1);
        push(6'b000001, DEB + 4);
        echo_exp++;
        check("R5", int'(mute_on), 0);
        push(6'b000001, DEB + 4);
        echo_exp++;
        check("R5", int'(mute_on), 1);

        // R6 preset advance with wrap
        exp_preset = 0;
        for (int k = 0; k < NP + 2; k++) begin
            push(6'b000010, DEB + 4);
            echo_exp++;
            exp_preset = next_preset(exp_preset);
            check("R6", int'(preset_idx), exp_preset);
        end

        // R7 dead pins in alternate mode
        for (int p = 2; p < 6; p++) push(6'(1 << p), DEB + 4);
        check_counts("R7");
        check("R7", int'(alt_mode), 1);

        // R9 exit chord returns to tone mode
        @(negedge clk);
        pins_n = pins_n & ~6'b001100;
        cycles(DEB + HOLD + 10);
        check("R9", int'(alt_mode), 0);
        pins_n = pins_n | 6'b001100;
        cycles(DEB + 6);
        push(6'b000001, DEB + 4);
        expc[0]++; echo_exp++;
        check_counts("R9");
        check("R7", int'(mute_on), 1);
        check("R7", int'(preset_idx), exp_preset);

        done = 1;
        finish_run();
    end
endmodule